// File: doc/BRIEF.md
# Adaptive Bang-Bang Fine Frequency Tuner

This block is the fine tuning loop of a burst-mode digital PLL. A separate coarse loop sets a 7-bit oscillator code; once that loop signals that its error is zero, this block takes over and trims a separate 9-bit fine code. At the end of every burst a one-bit phase decision arrives. It reports whether the oscillator edge that should line up with the reference edge came early or late. The block moves the fine code one step in the direction that pulls that edge toward the reference.

The step size adapts to the error. It starts large, so the loop acquires quickly with high bandwidth. Each time the phase decision reverses, the step halves, until it reaches a step of one and the loop settles with low bandwidth. When the coarse-lock flag drops, the code goes back to mid-scale and the step goes back to its largest value. A settled flag reports when the step is one and the last four decisions alternate. The phase detector and the DAC that the code drives sit outside this block.

Top module: `fine_bb_tuner`

## Requirements
- R1: While rst_n is low or coarse_lock is low, fine_code is forced to 256 (mid-scale), the step size returns to 16, the decision history is cleared and fine_settled is 0. These values appear on the clock edge that samples the condition.
- R2: While coarse_lock is low, pulses on burst_done and values on late have no effect. After coarse_lock rises, the first update uses step 16 and starts from 256.
- R3: fine_code changes only on the clock edge that samples burst_done high with coarse_lock high. It holds its value in every other locked cycle.
- R4: late = 1 (late edge, oscillator too slow) raises fine_code by the step. late = 0 (early edge, oscillator too fast) lowers it by the step. The new code is visible one clock after the strobe.
- R5: The step starts at 16. When a decision differs from the previous decision since lock, the step halves before it is applied. The step never goes below 1, and it is always a power of two between 1 and 16.
- R6: fine_code saturates at 511 when raised and at 0 when lowered, and it never wraps.
- R7: fine_settled is 1 exactly when the step is 1 and at least four decisions have been made since lock, with each of the last four decisions different from the one before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| coarse_lock | input | 1 | Coarse loop reports zero error; enables the fine loop |
| burst_done | input | 1 | One-cycle strobe at the end of a burst |
| late | input | 1 | Phase decision for the burst just ended: 1 = late, 0 = early |
| fine_code | output | 9 | Fine oscillator tuning code |
| fine_settled | output | 1 | Fine loop has converged |

## Verification
On every cycle, the assertions check the following: the mid-scale value while unlocked, the code holding between strobes, the direction of each move, that the step stays a power of two and never grows within a lock period, and that settled is only ever reported at the minimum step. The exact step sequence does not show up as a per-cycle property, so only the bench scenarios can demonstrate it. The same holds for halving on reversal, the point where settled first rises and later drops again, clamping at both ends of the code range, and the restart to mid-scale with a full step after lock is lost. The bench compares each of these against its own model of the requirements.

// File: rtl/fine_bb_tuner.sv
module fine_bb_tuner #(
  parameter int CODE_W    = 9,
  parameter int STEP_INIT = 16,
  parameter int HIST_N    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              coarse_lock,
  input  logic              burst_done,
  input  logic              late,
  output logic [CODE_W-1:0] fine_code,
  output logic              fine_settled
);

  localparam int SW  = $clog2(STEP_INIT + 1);
  localparam int CW  = $clog2(HIST_N + 1);
  localparam logic [CODE_W-1:0] MID  = CODE_W'(1 << (CODE_W - 1));
  localparam logic [CODE_W-1:0] TOP  = {CODE_W{1'b1}};

  logic [CODE_W-1:0] code_q;
  logic [SW-1:0]     step_q;
  logic [HIST_N-1:0] hist_q;
  logic [CW-1:0]     cnt_q;

  logic              reversal;
  logic [SW-1:0]     step_nxt;
  logic [CODE_W:0]   up_sum;
  logic [CODE_W-1:0] code_nxt;
  logic              alt_all;
  logic              update;

  assign update   = coarse_lock && burst_done;
  assign reversal = (cnt_q != '0) && (late != hist_q[0]);
  assign step_nxt = (reversal && step_q > SW'(1)) ? (step_q >> 1) : step_q;
  assign up_sum   = {1'b0, code_q} + (CODE_W+1)'(step_nxt);

  always_comb begin
    if (late)
      code_nxt = up_sum[CODE_W] ? TOP : up_sum[CODE_W-1:0];
    else
      code_nxt = (code_q >= CODE_W'(step_nxt)) ? code_q - CODE_W'(step_nxt) : '0;
  end

  always_comb begin
    alt_all = 1'b1;
    for (int i = 0; i < HIST_N - 1; i++)
      alt_all = alt_all & (hist_q[i] ^ hist_q[i+1]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !coarse_lock) begin
      code_q <= MID;
      step_q <= SW'(STEP_INIT);
      hist_q <= '0;
      cnt_q  <= '0;
    end else if (update) begin
      code_q <= code_nxt;
      step_q <= step_nxt;
      hist_q <= {hist_q[HIST_N-2:0], late};
      if (cnt_q != CW'(HIST_N))
        cnt_q <= cnt_q + CW'(1);
    end
  end

  assign fine_code    = code_q;
  assign fine_settled = (step_q == SW'(1)) && (cnt_q == CW'(HIST_N)) && alt_all;

endmodule

module fine_bb_tuner_chk #(
  parameter int CODE_W = 9,
  parameter int SW     = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              coarse_lock,
  input logic              burst_done,
  input logic              late,
  input logic [CODE_W-1:0] fine_code,
  input logic              fine_settled,
  input logic [SW-1:0]     step_q
);

  // R1
  unlock_mid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !coarse_lock |=> (fine_code == CODE_W'(1 << (CODE_W - 1))) && !fine_settled);

  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    coarse_lock && !burst_done |=> $stable(fine_code));

  // R4
  late_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    coarse_lock && burst_done && late |=> fine_code >= $past(fine_code));

  // R4
  early_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    coarse_lock && burst_done && !late |=> fine_code <= $past(fine_code));

  // R5
  step_pow2_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(step_q) == 1);

  // R5
  step_shrink_chk: assert property (@(posedge clk) disable iff (!rst_n)
    coarse_lock && burst_done |=> step_q <= $past(step_q));

  // R7
  settled_min_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fine_settled |-> step_q == SW'(1));

endmodule

bind fine_bb_tuner fine_bb_tuner_chk #(.CODE_W(CODE_W), .SW(SW)) chk_i (
  .clk(clk), .rst_n(rst_n), .coarse_lock(coarse_lock), .burst_done(burst_done),
  .late(late), .fine_code(fine_code), .fine_settled(fine_settled), .step_q(step_q)
);

// File: tb/fine_bb_tuner_tb_top.sv
module fine_bb_tuner_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       coarse_lock = 1'b0;
  logic       burst_done = 1'b0;
  logic       late = 1'b0;
  logic [8:0] fine_code;
  logic       fine_settled;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int m_code, m_step, m_cnt;
  logic m_prev;
  logic [3:0] m_hist;

  always #2 clk = ~clk;

  fine_bb_tuner dut_i (
    .clk(clk), .rst_n(rst_n), .coarse_lock(coarse_lock), .burst_done(burst_done),
    .late(late), .fine_code(fine_code), .fine_settled(fine_settled)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model_clear();
    m_code = 256; m_step = 16; m_cnt = 0; m_hist = '0; m_prev = 1'b0;
  endtask

  function automatic bit model_settled();
    return (m_step == 1) && (m_cnt >= 4) &&
           (m_hist[0] != m_hist[1]) && (m_hist[1] != m_hist[2]) && (m_hist[2] != m_hist[3]);
  endfunction

  // drive one burst decision; check code and settled one clock later
  task automatic burst(input logic l, input string req);
    @(negedge clk);
    burst_done = 1'b1; late = l;
    @(negedge clk);
    burst_done = 1'b0;
    if (coarse_lock) begin
      if (m_cnt > 0 && l != m_prev && m_step > 1) m_step = m_step / 2;
      m_code = l ? m_code + m_step : m_code - m_step;
      if (m_code > 511) m_code = 511;
      if (m_code < 0) m_code = 0;
      m_prev = l; m_hist = {m_hist[2:0], l};
      if (m_cnt < 4) m_cnt++;
    end
    chk(fine_code == 9'(m_code), req, fine_code, m_code);
    chk(fine_settled == model_settled(), "R7", fine_settled, model_settled());
  endtask

  task automatic relock();
    @(negedge clk); coarse_lock = 1'b0;
    @(negedge clk); coarse_lock = 1'b1;
    model_clear();
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(fine_code == 9'd256, "R1", fine_code, 256);
    chk(fine_settled == 1'b0, "R1", fine_settled, 0);
  endtask

  task automatic t_holdoff();
    model_clear();
    for (int i = 0; i < 3; i++) burst(1'b1, "R2");
    burst(1'b0, "R2");
    chk(fine_code == 9'd256, "R2", fine_code, 256);
  endtask

  task automatic t_steps_and_idle();
    relock();
    burst(1'b1, "R4");
    chk(fine_code == 9'd272, "R4", fine_code, 272);
    repeat (5) @(negedge clk);
    chk(fine_code == 9'd272, "R3", fine_code, 272);
    burst(1'b1, "R4");
    chk(fine_code == 9'd288, "R4", fine_code, 288);
    burst(1'b0, "R5");
    chk(fine_code == 9'd280, "R5", fine_code, 280);
  endtask

  task automatic t_converge();
    relock();
    burst(1'b1, "R5");
    burst(1'b0, "R5");
    burst(1'b1, "R5");
    burst(1'b0, "R5");
    chk(fine_code == 9'd266 && !fine_settled, "R7", fine_code, 266);
    burst(1'b1, "R5");
    chk(fine_code == 9'd267, "R5", fine_code, 267);
    chk(fine_settled == 1'b1, "R7", fine_settled, 1);
    burst(1'b0, "R5");
    chk(fine_code == 9'd266, "R5", fine_code, 266);
    burst(1'b0, "R7");
    chk(fine_settled == 1'b0, "R7", fine_settled, 0);
  endtask

  task automatic t_sat_high();
    relock();
    for (int i = 0; i < 17; i++) burst(1'b1, "R6");
    chk(fine_code == 9'd511, "R6", fine_code, 511);
  endtask

  task automatic t_sat_low();
    relock();
    for (int i = 0; i < 18; i++) burst(1'b0, "R6");
    chk(fine_code == 9'd0, "R6", fine_code, 0);
  endtask

  task automatic t_unlock_restart();
    relock();
    burst(1'b1, "R5"); burst(1'b0, "R5"); burst(1'b1, "R5");
    @(negedge clk); coarse_lock = 1'b0;
    @(negedge clk);
    chk(fine_code == 9'd256, "R1", fine_code, 256);
    coarse_lock = 1'b1; model_clear();
    burst(1'b0, "R2");
    chk(fine_code == 9'd240, "R2", fine_code, 240);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_holdoff();
    t_steps_and_idle();
    t_converge();
    t_sat_high();
    t_sat_low();
    t_unlock_restart();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule